// File: doc/BRIEF.md
# Descriptor Condition and Branch Evaluator

This block sits beside the command sequencer of a descriptor-driven DMA channel. When the sequencer finishes a descriptor's work, it presents the descriptor's three 2-bit policy fields, the three select registers, the device status bits, the current command pointer and the descriptor's branch target, and raises an evaluate strobe for one cycle. The block then decides whether the channel must stall, whether an interrupt is raised, and where the next descriptor lives.

Each policy (stall, interrupt, branch) is tested against its own select register. A select register carries a 4-bit mask and a 4-bit compare value. The condition holds when the low four device status bits agree with the compare value in every bit position the mask enables. The policy code then decides whether the action is never taken, taken when the condition holds, taken when it fails, or always taken. A stall takes precedence: when the stall test fires, no interrupt is raised and the pointer and branch-taken bit stay as they were, so that the descriptor can be retried later. Otherwise the interrupt decision and the pointer update are committed together.

The interrupt output is a single-cycle pulse for the channel's register unit to latch. The next pointer and the branch-taken flag are held until the next committed evaluation.

Top module: `dsc_cond_branch`

## Requirements
- R1: After reset, done_o, wait_o and irq_o are 0, bt_o is 0 and next_ptr_o is 0.
- R2: A select register's condition is true when, for every bit i in 0..3 with select bit 16+i set, device status bit i equals select bit i; the other select bits play no part.
- R3: cmd_i holds three policy fields: stall in bits 1:0, branch in bits 3:2, interrupt in bits 5:4. Each field encodes 0 never, 1 when its condition is true, 2 when its condition is false, 3 always.
- R4: When the stall policy fires, wait_o is 1, irq_o stays 0, and next_ptr_o and bt_o keep their previous values.
- R5: When the stall policy does not fire and the interrupt policy fires, irq_o is 1 for exactly the one cycle in which done_o is 1.
- R6: When the stall policy does not fire and the branch policy fires, next_ptr_o becomes br_tgt_i and bt_o becomes 1.
- R7: When neither the stall nor the branch policy fires, next_ptr_o becomes cur_ptr_i plus 16, wrapping modulo 2^32, and bt_o becomes 0.
- R8: Device status bits 7:4 have no effect on any output.
- R9: All results appear in the cycle after eval_i is sampled high, with done_o 1 for that cycle only; without eval_i, done_o and irq_o are 0 and wait_o, next_ptr_o and bt_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate the presented descriptor this cycle |
| cmd_i | input | 6 | Policy fields: stall 1:0, branch 3:2, interrupt 5:4 |
| sel_irq_i | input | 32 | Interrupt select: mask 19:16, value 3:0 |
| sel_br_i | input | 32 | Branch select: mask 19:16, value 3:0 |
| sel_wait_i | input | 32 | Stall select: mask 19:16, value 3:0 |
| dev_stat_i | input | 8 | Device status bits, low four compared |
| cur_ptr_i | input | 32 | Current command pointer |
| br_tgt_i | input | 32 | Branch target from the descriptor |
| done_o | output | 1 | Evaluation result valid, one cycle |
| wait_o | output | 1 | Stall decision of the last evaluation |
| irq_o | output | 1 | Interrupt request pulse |
| next_ptr_o | output | 32 | Next command pointer |
| bt_o | output | 1 | Branch-taken status |

## Verification
Every result of an evaluation is registered once, so done_o, wait_o, irq_o, next_ptr_o and bt_o are all due one cycle after the clock edge that samples eval_i. The bench drives each evaluation on a falling edge, checks all outputs on the following falling edge, then holds eval_i low for one more cycle and checks that done_o and irq_o have dropped and the held values are unchanged while the pointer inputs are deliberately disturbed. The sweep covers every policy code combination against every low status value for several mask and value patterns, with random upper status bits and a pointer at the wrap boundary.

// File: rtl/dsc_cond_pkg.sv
`timescale 1ns/1ps
package dsc_cond_pkg;

  typedef enum logic [1:0] {
    POL_NEVER    = 2'd0,
    POL_IF_MATCH = 2'd1,
    POL_IF_MISS  = 2'd2,
    POL_ALWAYS   = 2'd3
  } pol_e;

  localparam int unsigned POL_W     = 2;
  localparam int unsigned NUM_LANES = 3;
  // lane index equals field position in cmd_i (lane k at bits 2k+1:2k)
  localparam int unsigned LANE_WAIT = 0;
  localparam int unsigned LANE_BR   = 1;
  localparam int unsigned LANE_IRQ  = 2;
  localparam int unsigned CMD_W     = NUM_LANES * POL_W;

endpackage

// File: rtl/dsc_cond_match.sv
`timescale 1ns/1ps
module dsc_cond_match #(
  parameter int unsigned SEL_W    = 32,
  parameter int unsigned COND_W   = 4,
  parameter int unsigned MASK_LSB = 16
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [COND_W-1:0] stat_i,
  output logic              match_o
);

  logic [COND_W-1:0] mask;
  logic [COND_W-1:0] value;
  logic              unused_sel;

  assign mask       = sel_i[MASK_LSB +: COND_W];
  assign value      = sel_i[COND_W-1:0];
  assign unused_sel = ^{sel_i[SEL_W-1:MASK_LSB+COND_W], sel_i[MASK_LSB-1:COND_W]};

  // true when no enabled bit differs
  assign match_o = ~|((stat_i ^ value) & mask);

  initial begin
    assert (MASK_LSB >= COND_W && MASK_LSB + COND_W < SEL_W)
      else $error("select layout does not fit");
  end

endmodule

// File: rtl/dsc_policy_gate.sv
`timescale 1ns/1ps
module dsc_policy_gate
  import dsc_cond_pkg::*;
(
  input  pol_e pol_i,
  input  logic match_i,
  output logic fire_o
);

  always_comb begin
    unique case (pol_i)
      POL_NEVER:    fire_o = 1'b0;
      POL_IF_MATCH: fire_o = match_i;
      POL_IF_MISS:  fire_o = ~match_i;
      POL_ALWAYS:   fire_o = 1'b1;
      default:      fire_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsc_ptr_step.sv
`timescale 1ns/1ps
module dsc_ptr_step #(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             take_i,
  input  logic [PTR_W-1:0] cur_ptr_i,
  input  logic [PTR_W-1:0] tgt_i,
  output logic [PTR_W-1:0] next_ptr_o,
  output logic             bt_o
);

  localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

  logic [PTR_W-1:0] ptr_q;
  logic             bt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      bt_q  <= 1'b0;
    end else if (upd_i) begin
      ptr_q <= take_i ? tgt_i : cur_ptr_i + STEP;
      bt_q  <= take_i;
    end
  end

  assign next_ptr_o = ptr_q;
  assign bt_o       = bt_q;

  p_branch_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(upd_i && take_i) |-> (next_ptr_o == $past(tgt_i)) && bt_o);

  p_seq_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(upd_i && !take_i) |-> (next_ptr_o == $past(cur_ptr_i) + STEP) && !bt_o);

  p_hold_no_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(upd_i) |-> $stable(next_ptr_o) && $stable(bt_o));

endmodule

// File: rtl/dsc_cond_branch.sv
`timescale 1ns/1ps
module dsc_cond_branch
  import dsc_cond_pkg::*;
#(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned SEL_W      = 32,
  parameter int unsigned STAT_W     = 8,
  parameter int unsigned COND_W     = 4,
  parameter int unsigned MASK_LSB   = 16,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [SEL_W-1:0]  sel_irq_i,
  input  logic [SEL_W-1:0]  sel_br_i,
  input  logic [SEL_W-1:0]  sel_wait_i,
  input  logic [STAT_W-1:0] dev_stat_i,
  input  logic [PTR_W-1:0]  cur_ptr_i,
  input  logic [PTR_W-1:0]  br_tgt_i,
  output logic              done_o,
  output logic              wait_o,
  output logic              irq_o,
  output logic [PTR_W-1:0]  next_ptr_o,
  output logic              bt_o
);

  logic [SEL_W-1:0]     sel_arr [NUM_LANES];
  logic [NUM_LANES-1:0] match;
  logic [NUM_LANES-1:0] fire;
  logic [COND_W-1:0]    cond_stat;
  logic                 unused_stat;
  logic                 go;

  assign sel_arr[LANE_WAIT] = sel_wait_i;
  assign sel_arr[LANE_BR]   = sel_br_i;
  assign sel_arr[LANE_IRQ]  = sel_irq_i;

  assign cond_stat   = dev_stat_i[COND_W-1:0];
  assign unused_stat = ^dev_stat_i[STAT_W-1:COND_W];

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    dsc_cond_match #(
      .SEL_W   (SEL_W),
      .COND_W  (COND_W),
      .MASK_LSB(MASK_LSB)
    ) u_match (
      .sel_i  (sel_arr[k]),
      .stat_i (cond_stat),
      .match_o(match[k])
    );

    dsc_policy_gate u_gate (
      .pol_i  (pol_e'(cmd_i[k*POL_W +: POL_W])),
      .match_i(match[k]),
      .fire_o (fire[k])
    );
  end

  // stall test decides first; interrupt and branch commit only without it
  assign go = eval_i & ~fire[LANE_WAIT];

  logic done_q, wait_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      wait_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= eval_i;
      irq_q  <= go & fire[LANE_IRQ];
      if (eval_i) wait_q <= fire[LANE_WAIT];
    end
  end

  dsc_ptr_step #(
    .PTR_W     (PTR_W),
    .DESC_BYTES(DESC_BYTES)
  ) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (go),
    .take_i    (fire[LANE_BR]),
    .cur_ptr_i (cur_ptr_i),
    .tgt_i     (br_tgt_i),
    .next_ptr_o(next_ptr_o),
    .bt_o      (bt_o)
  );

  assign done_o = done_q;
  assign wait_o = wait_q;
  assign irq_o  = irq_q;

  p_irq_needs_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o && !wait_o);

  p_done_after_eval_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(eval_i));

  p_wait_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(wait_o) && !irq_o);

  p_stall_freezes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && wait_o |-> $stable(next_ptr_o) && $stable(bt_o) && !irq_o);

endmodule

// File: tb/dsc_cond_branch_bench.sv
`timescale 1ns/1ps
module dsc_cond_branch_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval;
  logic [5:0]  cmd;
  logic [31:0] sel_irq, sel_br, sel_wait;
  logic [7:0]  stat;
  logic [31:0] cur_ptr, tgt;
  logic        done, wait_f, irq, bt;
  logic [31:0] nptr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [31:0] exp_ptr;
  logic        exp_bt;
  logic        exp_wait;

  always #5 clk = ~clk;

  dsc_cond_branch u_dsc_cond_branch (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .cmd_i(cmd),
    .sel_irq_i(sel_irq), .sel_br_i(sel_br), .sel_wait_i(sel_wait),
    .dev_stat_i(stat), .cur_ptr_i(cur_ptr), .br_tgt_i(tgt),
    .done_o(done), .wait_o(wait_f), .irq_o(irq), .next_ptr_o(nptr), .bt_o(bt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit cond_of(logic [31:0] sel, logic [7:0] st);
    bit ok = 1;
    for (int i = 0; i < 4; i++)
      if (sel[16+i] && (st[i] != sel[i])) ok = 0;
    return ok;
  endfunction

  function automatic bit pol_of(logic [1:0] p, bit c);
    return (p == 2'd3) || (p == 2'd1 && c) || (p == 2'd2 && !c);
  endfunction

  task automatic run_eval(logic [5:0] c, logic [7:0] st, logic [31:0] sw,
                          logic [31:0] sb, logic [31:0] si,
                          logic [31:0] cp, logic [31:0] bg);
    bit w, b, q;
    w = pol_of(c[1:0], cond_of(sw, st));
    b = pol_of(c[3:2], cond_of(sb, st));
    q = pol_of(c[5:4], cond_of(si, st));
    cmd = c; stat = st; sel_wait = sw; sel_br = sb; sel_irq = si;
    cur_ptr = cp; tgt = bg; eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
    exp_wait = w;
    if (!w) begin
      exp_ptr = b ? bg : cp + 32'd16;
      exp_bt  = b;
    end
    check("R9 done", {31'd0, done}, 32'd1);
    check("R3 wait", {31'd0, wait_f}, {31'd0, w});
    check("R5 irq", {31'd0, irq}, {31'd0, !w && q});
    check(w ? "R4 ptr" : (b ? "R6 ptr" : "R7 ptr"), nptr, exp_ptr);
    check(w ? "R4 bt" : (b ? "R6 bt" : "R7 bt"), {31'd0, bt}, {31'd0, exp_bt});
    // disturb inputs while idle
    cur_ptr = ~cp; tgt = ~bg; cmd = ~c; stat = ~st;
    @(negedge clk);
    check("R9 idle done", {31'd0, done}, 32'd0);
    check("R5 idle irq", {31'd0, irq}, 32'd0);
    check("R9 idle wait", {31'd0, wait_f}, {31'd0, exp_wait});
    check("R9 idle ptr", nptr, exp_ptr);
    check("R9 idle bt", {31'd0, bt}, {31'd0, exp_bt});
  endtask

  initial begin
    eval = 0; cmd = 0; sel_irq = 0; sel_br = 0; sel_wait = 0;
    stat = 0; cur_ptr = 0; tgt = 0;
    exp_ptr = 0; exp_bt = 0; exp_wait = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 wait", {31'd0, wait_f}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 ptr", nptr, 32'd0);
    check("R1 bt", {31'd0, bt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R8 sweep: all policy codes x all low status values x select patterns
    for (int s = 0; s < 4; s++) begin
      logic [31:0] sw, sb, si;
      sw = {12'hABC, 4'(s * 5 + 1), 12'h5A5, 4'(s * 3 + 2)};
      sb = {12'h123, 4'(15 - s * 4), 12'h0F0, 4'(s * 7)};
      si = {12'hFED, 4'(s * 6 + 3), 12'hA5A, 4'(9 - s)};
      for (int c = 0; c < 64; c++) begin
        for (int st = 0; st < 16; st++) begin
          logic [7:0] sv;
          sv = {4'($urandom_range(15)), 4'(st)};
          run_eval(6'(c), sv, sw, sb, si,
                   {$urandom_range(32'h0FFF_FFFF), 4'h0}, $urandom);
        end
      end
    end

    // R2: zero mask always matches, full mask needs exact equality
    run_eval(6'b01_01_00, 8'hF3, 32'h0000_0000, 32'h000F_0003, 32'h0000_0005,
             32'h1000, 32'h2000);
    check("R2 full mask branch", {31'd0, bt}, 32'd1);
    // R8: only upper status bits differ from the selected value -> still match
    run_eval(6'b01_01_00, 8'h73, 32'h0, 32'h000F_0003, 32'h000F_0003,
             32'h1100, 32'h3300);
    check("R8 upper bits ignored", nptr, 32'h3300);
    // R7 wrap boundary
    run_eval(6'b00_00_00, 8'h00, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFF0, 32'h44);
    check("R7 wrap", nptr, 32'h0);
    // R4 stall always keeps the wrapped pointer
    run_eval(6'b11_11_11, 8'h00, 32'h0, 32'h0, 32'h0, 32'h500, 32'h600);
    check("R4 stall hold", nptr, 32'h0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule